// File: doc/BRIEF.md
# DMA Command Descriptor Builder

This block takes one transfer request and turns it into command descriptors placed in a circular command ring shared with a DMA engine. A request holds a 64-bit host address, a 32-bit local address, a byte length that is a multiple of 16, and a direction flag. Each descriptor is eight 32-bit words. The block writes the words one per cycle through a plain memory write port. After the last word it publishes the new ring write pointer and then pulses `done`.

The length is counted in 16-byte units, and one line holds at most 1024 units. A transfer that fits in one line becomes a single descriptor. A longer transfer becomes a multi-line main descriptor with an odd line-count encoding. If some units are left over, a second descriptor in the following ring slot carries them. When that second descriptor exists, only it asks for the completion interrupts.

Top module: `dma_desc_gen`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0, `mem_we` is 0 and `wr_ptr` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the cycle after `done`. A request held on the inputs while the block is busy is ignored: it writes nothing and does not move `wr_ptr`.
- R3: Let U be the length divided by 16. When U is at most 1024, exactly one descriptor is written. Its line size is U, its line count is 1, both pitches are 1, and both interrupt flags are set.
- R4: Descriptor word 2 (local word) holds 1 in bit 0, local address bits 29:4 in place, and the direction flag in bit 31. All its other bits are 0.
- R5: Word 0 holds host address bits 31:0 and word 1 holds bits 63:32. Word 3 holds the host pitch in bits 14:3 and the local pitch in bits 30:19. Word 4 holds 1 in bit 1, the line size in bits 14:4, the local interrupt flag in bit 15, the line count in bits 27:16 and the host interrupt flag in bit 31. Words 5 to 7 are 0.
- R6: When U exceeds 1024, let N = U / 1024. The main descriptor has line size 1024, both pitches 1024, and line-count field 2*N-1.
- R7: When U exceeds 1024 and R = U mod 1024 is nonzero, a second descriptor goes into the next ring slot. Both its addresses are the request's plus N*16384 bytes. Its line size is R, its line count is 1, and both its pitches are 1.
- R8: When a second descriptor exists, the main descriptor's bits 15 and 31 of word 4 are 0 and the second descriptor has both set. A split transfer with R = 0 keeps both flags on its main descriptor.
- R9: Descriptor in slot S occupies word addresses S*8 to S*8+7. The slot index advances modulo RING_SLOTS, so slot 0 follows slot RING_SLOTS-1.
- R10: `wr_ptr` becomes (next free slot)*4 once all descriptors are written. `done` is a one-cycle pulse in the cycle after that update. `done` is first high 9 cycles after the accepting edge for one descriptor and 17 cycles after it for two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_host_addr | input | 64 | Host-side byte address |
| req_loc_addr | input | 32 | Local-side byte address |
| req_len | input | 32 | Byte length, multiple of 16 |
| req_upstream | input | 1 | Direction flag, 1 = local to host |
| mem_we | output | 1 | Ring word write strobe |
| mem_addr | output | clog2(RING_SLOTS)+3 | Ring word address (slot*8+word) |
| mem_wdata | output | 32 | Ring word data |
| wr_ptr | output | 32 | Published ring write pointer |
| done | output | 1 | Request finished pulse |

## Verification
Descriptor words leave the block one per cycle. The first word is written in the cycle after the accepting edge, and `wr_ptr` changes on the edge after the last word. `done` is first high 9 cycles after the accepting edge for one descriptor and 17 for two. The bench drives inputs and samples outputs on falling edges. It counts falling edges from acceptance until `done` and compares the count with 9 or 17. It records every ring write into a model memory on rising edges, and checks descriptors and `wr_ptr` only after `done`, when all their writes have landed.

// File: rtl/dma_desc_gen.sv
module dma_desc_gen #(
  parameter int RING_SLOTS = 128,
  parameter int UNIT_BYTES = 16,
  parameter int MAX_UNITS  = 1024
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [63:0]                     req_host_addr,
  input  logic [31:0]                     req_loc_addr,
  input  logic [31:0]                     req_len,
  input  logic                            req_upstream,
  output logic                            mem_we,
  output logic [$clog2(RING_SLOTS)+2:0]   mem_addr,
  output logic [31:0]                     mem_wdata,
  output logic [31:0]                     wr_ptr,
  output logic                            done
);
  localparam int SLOT_W  = $clog2(RING_SLOTS);
  localparam int UNIT_SH = $clog2(UNIT_BYTES);
  localparam int LINE_SH = $clog2(MAX_UNITS);
  localparam int UNITS_W = 32 - UNIT_SH;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_PUB, S_DONE} st_t;

  st_t               st;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        wsel;
  logic              second;
  logic [63:0]       h_addr;
  logic [31:0]       l_addr;
  logic [UNITS_W-1:0] units;
  logic              up;

  logic               split, has_rem, cur_irq, one_line;
  logic [UNITS_W-1:0] nlines;
  logic [LINE_SH-1:0] rem;
  logic [31:0]        covered;
  logic [63:0]        cur_host;
  logic [31:0]        cur_loc;
  logic [10:0]        cur_size;
  logic [11:0]        cur_lines, cur_pitch;
  logic [SLOT_W-1:0]  slot_nx;

  assign split    = units > UNITS_W'(MAX_UNITS);
  assign nlines   = units >> LINE_SH;
  assign rem      = units[LINE_SH-1:0];
  assign has_rem  = split && (rem != '0);
  assign covered  = 32'(nlines) << (LINE_SH + UNIT_SH);
  assign one_line = second || !split;
  assign cur_irq  = second || !has_rem;
  assign cur_host = second ? h_addr + {32'd0, covered} : h_addr;
  assign cur_loc  = second ? l_addr + covered : l_addr;
  assign cur_size = second ? 11'(rem) : (split ? 11'(MAX_UNITS) : 11'(units));
  assign cur_lines = one_line ? 12'd1 : 12'((nlines << 1) - 1'b1);
  assign cur_pitch = one_line ? 12'd1 : 12'(MAX_UNITS);
  assign slot_nx  = (slot == SLOT_W'(RING_SLOTS - 1)) ? '0 : slot + 1'b1;

  always_comb begin
    case (wsel)
      3'd0:    mem_wdata = cur_host[31:0];
      3'd1:    mem_wdata = cur_host[63:32];
      3'd2:    mem_wdata = {up, 1'b0, cur_loc[29:4], 3'b000, 1'b1};
      3'd3:    mem_wdata = {1'b0, cur_pitch, 4'd0, cur_pitch, 3'd0};
      3'd4:    mem_wdata = {cur_irq, 3'd0, cur_lines, cur_irq, cur_size, 2'b00, 1'b1, 1'b0};
      default: mem_wdata = 32'd0;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = {slot, wsel};
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      slot   <= '0;
      wsel   <= '0;
      second <= 1'b0;
      h_addr <= '0;
      l_addr <= '0;
      units  <= '0;
      up     <= 1'b0;
      wr_ptr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          h_addr <= req_host_addr;
          l_addr <= req_loc_addr;
          units  <= req_len[31:UNIT_SH];
          up     <= req_upstream;
          wsel   <= '0;
          second <= 1'b0;
          st     <= S_WR;
        end
        S_WR: begin
          wsel <= wsel + 1'b1;
          if (wsel == 3'd7) begin
            slot <= slot_nx;
            if (has_rem && !second) second <= 1'b1;
            else                    st     <= S_PUB;
          end
        end
        S_PUB: begin
          wr_ptr <= {{(30-SLOT_W){1'b0}}, slot, 2'b00};
          st     <= S_DONE;
        end
        default: begin
          second <= 1'b0;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !req_ready); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R2
  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> $stable(wr_ptr)); // R10
  AST_MAIN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr[2:0] == 3'd4 && has_rem && !second) |-> (mem_wdata[31] == 1'b0 && mem_wdata[15] == 1'b0)); // R8
endmodule

// File: tb/dma_desc_gen_bench.sv
module dma_desc_gen_bench;
  localparam int SLOTS = 128;
  localparam int AW    = $clog2(SLOTS) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_host_addr = '0;
  logic [31:0] req_loc_addr = '0;
  logic [31:0] req_len = '0;
  logic req_upstream = 1'b0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] wr_ptr;
  logic done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat;
  logic [31:0] ring [SLOTS*8];

  always #2 clk = ~clk;

  dma_desc_gen #(.RING_SLOTS(SLOTS)) u_dma_desc_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_host_addr(req_host_addr), .req_loc_addr(req_loc_addr), .req_len(req_len),
    .req_upstream(req_upstream), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .done(done));

  always @(posedge clk) if (mem_we) ring[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [63:0] h, logic [31:0] l, logic [31:0] len, logic u);
    @(negedge clk);
    req_host_addr = h; req_loc_addr = l; req_len = len; req_upstream = u;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_desc(string tag, int slot, logic [63:0] h, logic [31:0] l,
                            int size, int lines, int pitch, bit irq, bit u);
    logic [31:0] e [8];
    e[0] = h[31:0];
    e[1] = h[63:32];
    e[2] = {u, 1'b0, l[29:4], 4'b0001};
    e[3] = (32'(pitch) << 19) | (32'(pitch) << 3);
    e[4] = (32'(irq) << 31) | (32'(lines) << 16) | (32'(irq) << 15) | (32'(size) << 4) | 32'd2;
    for (int k = 5; k < 8; k++) e[k] = 32'd0;
    for (int k = 0; k < 8; k++)
      check($sformatf("%s slot %0d word %0d", tag, slot, k), {32'd0, ring[slot*8+k]}, {32'd0, e[k]});
  endtask

  task automatic t_reset;
    check("R1 req_ready", {63'd0, req_ready}, 64'd1);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 mem_we", {63'd0, mem_we}, 64'd0);
    check("R1 wr_ptr", {32'd0, wr_ptr}, 64'd0);
  endtask

  task automatic t_short;
    send(64'h0000_0001_2345_6780, 32'hFABC_DEF7, 32'h100, 1'b1);
    check("R10 latency one", 64'(lat), 64'd9);
    check_desc("R3 R4 R5 short", 0, 64'h0000_0001_2345_6780, 32'hFABC_DEF7, 16, 1, 1, 1'b1, 1'b1);
    check("R10 wr_ptr short", {32'd0, wr_ptr}, 64'd4);
  endtask

  task automatic t_edge1024;
    send(64'hAAAA_5555_0000_1000, 32'h0000_2000, 32'd16384, 1'b0);
    check_desc("R3 exact 1024", 1, 64'hAAAA_5555_0000_1000, 32'h0000_2000, 1024, 1, 1, 1'b1, 1'b0);
    check("R10 wr_ptr 1024", {32'd0, wr_ptr}, 64'd8);
  endtask

  task automatic t_split_rem;
    send(64'h0000_0010_0000_0000, 32'h0100_0000, 32'd32848, 1'b1);
    check("R10 latency two", 64'(lat), 64'd17);
    check_desc("R6 R8 main", 2, 64'h0000_0010_0000_0000, 32'h0100_0000, 1024, 3, 1024, 1'b0, 1'b1);
    check_desc("R7 R8 rem", 3, 64'h0000_0010_0000_8000, 32'h0100_8000, 5, 1, 1, 1'b1, 1'b1);
    check("R10 wr_ptr split", {32'd0, wr_ptr}, 64'd16);
  endtask

  task automatic t_split_exact;
    send(64'h0000_0000_0040_0000, 32'h0020_0000, 32'd49152, 1'b0);
    check("R10 latency no rem", 64'(lat), 64'd9);
    check_desc("R6 R8 no rem", 4, 64'h0000_0000_0040_0000, 32'h0020_0000, 1024, 5, 1024, 1'b1, 1'b0);
    check("R10 wr_ptr no rem", {32'd0, wr_ptr}, 64'd20);
  endtask

  task automatic t_1025;
    send(64'h0000_0000_0000_0000, 32'h0000_0000, 32'd16400, 1'b0);
    check_desc("R6 1025 main", 5, 64'd0, 32'd0, 1024, 1, 1024, 1'b0, 1'b0);
    check_desc("R7 1025 rem", 6, 64'h4000, 32'h4000, 1, 1, 1, 1'b1, 1'b0);
    check("R10 wr_ptr 1025", {32'd0, wr_ptr}, 64'd28);
  endtask

  task automatic t_busy;
    @(negedge clk);
    req_host_addr = 64'h1111; req_loc_addr = 32'h2220; req_len = 32'h20; req_upstream = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_host_addr = 64'h9999; req_loc_addr = 32'h8880; req_len = 32'h40; req_upstream = 1'b1;
    for (int k = 0; k < 5; k++) begin
      check("R2 ready low while busy", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check_desc("R2 busy kept first", 7, 64'h1111, 32'h2220, 2, 1, 1, 1'b1, 1'b0);
    check("R2 slot 8 untouched", {32'd0, ring[64]}, {32'd0, 32'hDEAD_BEEF});
    check("R2 wr_ptr one slot", {32'd0, wr_ptr}, 64'd32);
  endtask

  task automatic t_wrap;
    for (int k = 8; k < 127; k++) send(64'(k) << 8, 32'(k) << 8, 32'h10, 1'b0);
    check("R9 wr_ptr before wrap", {32'd0, wr_ptr}, 64'd508);
    send(64'h0000_0002_0000_0000, 32'h0300_0000, 32'd16400, 1'b1);
    check_desc("R9 main at last slot", 127, 64'h0000_0002_0000_0000, 32'h0300_0000, 1024, 1, 1024, 1'b0, 1'b1);
    check_desc("R9 rem at slot 0", 0, 64'h0000_0002_0000_4000, 32'h0300_4000, 1, 1, 1, 1'b1, 1'b1);
    check("R9 wr_ptr wrapped", {32'd0, wr_ptr}, 64'd4);
  endtask

  initial begin
    for (int k = 0; k < SLOTS*8; k++) ring[k] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_edge1024();
    t_split_rem();
    t_split_exact();
    t_1025();
    t_busy();
    t_wrap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule